// File: doc/BRIEF.md
# Measurement Reading ASCII Talker

This block turns one finished counter reading into a sixteen-byte ASCII string and hands it out byte by byte on an 8-bit bus. The reading arrives as:

- nine BCD mantissa digits;
- a decimal-point position;
- a one-digit exponent with its own sign;
- a mantissa sign flag and an overflow flag.

The string has a fixed exponential layout. Leading zero digits are sent as spaces, and every string ends with carriage return and line feed.

A pending flag records that a reading exists and has not yet been sent. The flag is set when the measurement gate closes, and it is cleared once the final byte has been taken. Bytes leave through a valid/accept pair, and an end marker accompanies the last byte. The device must be selected as talker, either by addressing or by a talk-always strap. It may talk only while the controller is not in its command phase.

Two mode inputs shape the behaviour:

- A wait mode raises a service request while a reading is pending.
- An on-the-fly mode sends the current reading whenever the device is a talker, whether or not anything is pending.

The reading inputs must stay stable while a string is in flight.

Top module: `meas_ascii_talker`

## Requirements
- R1: After reset, out_valid, out_en and srq are low. The next string starts at its first byte.
- R2: A string is 16 bytes, in this order: mantissa sign ('+' 0x2B or '-' 0x2D); ten bytes of mantissa with one decimal point; the exponent marker; the exponent sign ('+'/'-'); the exponent digit (0x30 + value); CR 0x0D; LF 0x0A.
- R3: With dp_pos = n (values above 9 treated as 9), the '.' byte (0x2E) follows the first n mantissa digits. Mantissa digit 0 is the most significant digit and sits in mant[35:32].
- R4: A mantissa digit is sent as 0x30 + value. Digits 0 to 7 are instead sent as a space (0x20) when they and every more significant digit are zero. Digit 8 is always sent as a number.
- R5: The exponent marker is 'O' (0x4F) when ovf is high and 'E' (0x45) otherwise.
- R6: out_valid stays low unless the device is talking and either a reading is pending, a string is part-way through, or fly_mode is high.
- R7: The pending flag sets in the cycle after a clock edge that sees gate fall, unless cnt_reset is high at that edge. It clears after the accepted LF byte. A set in the same cycle as that clear wins.
- R8: out_last is high exactly while the LF byte is offered.
- R9: While bus_cmd is high, out_valid, out_en and out_data are all zero in the same cycle. The string resumes at the next unsent byte once bus_cmd drops.
- R10: talk_strap makes the device a talker without talk_addr.
- R11: srq equals wait_mode AND pending. In continue mode (wait_mode low) no request is raised, but the reading is still sent.
- R12: With fly_mode high and the device talking, strings are sent back to back with no pending reading.
- R13: While out_valid is high and out_accept is low, the offered byte does not change and no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| gate | input | 1 | Measurement gate; its falling edge marks a finished reading |
| cnt_reset | input | 1 | Counter reset in progress; blocks the pending set |
| mant | input | 36 | Nine BCD digits, most significant in [35:32] |
| dp_pos | input | 4 | Number of digits before the decimal point |
| exp_val | input | 4 | Exponent digit |
| exp_neg | input | 1 | Exponent is negative |
| neg | input | 1 | Mantissa is negative |
| ovf | input | 1 | Reading overflowed |
| bus_cmd | input | 1 | Controller command phase; talker must stay off the bus |
| talk_addr | input | 1 | Device is addressed to talk |
| talk_strap | input | 1 | Talk-always strap |
| wait_mode | input | 1 | Raise a service request while a reading is pending |
| fly_mode | input | 1 | Send the current reading whenever talking |
| out_accept | input | 1 | Receiver takes the offered byte |
| out_data | output | 8 | Offered ASCII byte; zero when not driving |
| out_valid | output | 1 | A byte is offered |
| out_last | output | 1 | Offered byte is the final LF |
| out_en | output | 1 | Data lines are driven |
| srq | output | 1 | Service request |

## Verification
The risky coincidence is the acceptance of the final LF byte in the same cycle that a new gate closing sets the pending flag. To provoke it, the bench lowers gate at the falling clock edge just before the LF transfer. It then expects srq to stay high and a fresh string to start at its sign byte. A second overlap is a command phase arriving mid-string. This is judged by the bus going quiet in that same cycle and by the string later resuming at exactly the next byte. Random readings, random decimal positions including out-of-range values, and random accept stalls cover the string contents.

// File: rtl/meas_ascii_talker.sv
module meas_ascii_talker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gate,
  input  logic        cnt_reset,
  input  logic [35:0] mant,
  input  logic [3:0]  dp_pos,
  input  logic [3:0]  exp_val,
  input  logic        exp_neg,
  input  logic        neg,
  input  logic        ovf,
  input  logic        bus_cmd,
  input  logic        talk_addr,
  input  logic        talk_strap,
  input  logic        wait_mode,
  input  logic        fly_mode,
  input  logic        out_accept,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_last,
  output logic        out_en,
  output logic        srq
);
  localparam int NDIG = 9;
  localparam int PW = 4;
  localparam logic [PW-1:0] LAST_IDX = PW'(15);
  localparam logic [3:0] MAX_DP = 4'(NDIG);

  logic [PW-1:0] ptr;
  logic pending, gate_q;
  logic talking, fall, xfer;
  logic [3:0] dpc, k, m, dig;
  logic lead0, is_dp;
  logic [7:0] ch;

  assign talking   = ~bus_cmd & (talk_addr | talk_strap);
  assign fall      = gate_q & ~gate & ~cnt_reset;
  assign out_valid = talking & ((ptr != '0) | pending | fly_mode);
  assign out_last  = out_valid & (ptr == LAST_IDX);
  assign out_en    = talking;
  assign srq       = wait_mode & pending;
  assign xfer      = out_valid & out_accept;
  assign out_data  = talking ? ch : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      pending <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      gate_q <= gate;
      if (xfer) ptr <= ptr + 1'b1;
      if (fall) pending <= 1'b1;
      else if (xfer && out_last) pending <= 1'b0;
    end
  end

  always_comb begin
    dpc   = (dp_pos > MAX_DP) ? MAX_DP : dp_pos;
    k     = ptr - 4'd1;
    is_dp = (k == dpc);
    m     = (k < dpc) ? k : k - 4'd1;
    dig   = 4'd0;
    lead0 = 1'b1;
    for (int j = 0; j < NDIG; j++) begin
      if (m == 4'(j)) dig = mant[35-4*j -: 4];
      if (4'(j) <= m && mant[35-4*j -: 4] != 4'd0) lead0 = 1'b0;
    end
    unique case (ptr)
      4'd0:  ch = neg ? 8'h2D : 8'h2B;
      4'd11: ch = ovf ? 8'h4F : 8'h45;
      4'd12: ch = exp_neg ? 8'h2D : 8'h2B;
      4'd13: ch = 8'h30 + {4'h0, exp_val};
      4'd14: ch = 8'h0D;
      4'd15: ch = 8'h0A;
      default: begin
        if (is_dp) ch = 8'h2E;
        else if (lead0 && m < 4'(NDIG-1)) ch = 8'h20;
        else ch = 8'h30 + {4'h0, dig};
      end
    endcase
  end

  // R9
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd |-> (!out_valid && !out_en && out_data == 8'h00));

  // R8
  last_is_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_data == 8'h0A));

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_accept) |=> $stable(ptr));

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> pending);

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_last && !fall) |=> !pending);

  // R11
  srq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> wait_mode);

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_last) |=> (ptr == '0));
endmodule

// File: tb/meas_ascii_talker_test.sv
module meas_ascii_talker_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic gate = 0, cnt_reset = 0;
  logic [35:0] mant = '0;
  logic [3:0] dp_pos = 0, exp_val = 0;
  logic exp_neg = 0, neg = 0, ovf = 0;
  logic bus_cmd = 0, talk_addr = 0, talk_strap = 0, wait_mode = 0, fly_mode = 0;
  logic out_accept = 0;
  logic [7:0] out_data;
  logic out_valid, out_last, out_en, srq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  meas_ascii_talker uut (.clk(clk), .rst_n(rst_n), .gate(gate), .cnt_reset(cnt_reset),
    .mant(mant), .dp_pos(dp_pos), .exp_val(exp_val), .exp_neg(exp_neg), .neg(neg), .ovf(ovf),
    .bus_cmd(bus_cmd), .talk_addr(talk_addr), .talk_strap(talk_strap), .wait_mode(wait_mode),
    .fly_mode(fly_mode), .out_accept(out_accept), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .out_en(out_en), .srq(srq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(input int idx);
    int d, k, m;
    bit lz;
    d = (dp_pos > 9) ? 9 : int'(dp_pos);
    if (idx == 0) return neg ? 8'h2D : 8'h2B;
    if (idx <= 10) begin
      k = idx - 1;
      if (k == d) return 8'h2E;
      m = (k < d) ? k : k - 1;
      lz = 1;
      for (int j = 0; j <= m; j++) if (mant[35-4*j -: 4] != 0) lz = 0;
      if (lz && m < 8) return 8'h20;
      return 8'h30 + {4'h0, mant[35-4*m -: 4]};
    end
    if (idx == 11) return ovf ? 8'h4F : 8'h45;
    if (idx == 12) return exp_neg ? 8'h2D : 8'h2B;
    if (idx == 13) return 8'h30 + {4'h0, exp_val};
    if (idx == 14) return 8'h0D;
    return 8'h0A;
  endfunction

  task automatic new_reading();
    int lz;
    lz = $urandom % 10;
    for (int j = 0; j < 9; j++) mant[35-4*j -: 4] = (j < lz) ? 4'd0 : 4'($urandom % 10);
    dp_pos = 4'($urandom % 16);
    exp_val = 4'($urandom % 10);
    exp_neg = 1'($urandom); neg = 1'($urandom); ovf = 1'($urandom);
  endtask

  // R2 R3 R4 R5 R8 R13: take bytes idx a..b, stalling at random
  task automatic get_bytes(input int a, input int b, input int stall);
    int wd;
    for (int i = a; i <= b; i++) begin
      wd = 0;
      forever begin
        @(negedge clk);
        out_accept = (($urandom % 100) >= stall);
        #1;
        if (out_valid && !out_accept)
          chk(out_data == exp_char(i), "R13 stalled byte", out_data, exp_char(i));
        if (out_valid && out_accept) break;
        wd++;
        if (wd > 300) begin
          chk(0, "R6 byte never offered", 0, i);
          out_accept = 0;
          return;
        end
      end
      chk(out_data == exp_char(i), (i == 0) ? "R2 sign" : (i <= 10) ? "R3/R4 mantissa" :
          (i == 11) ? "R5 marker" : "R2 tail", out_data, exp_char(i));
      chk(out_last == (i == 15), "R8 last marker", out_last, (i == 15));
    end
    @(negedge clk);
    out_accept = 0;
  endtask

  task automatic measure();
    @(negedge clk) gate = 1;
    @(negedge clk) gate = 0;
    @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen;
    seen = 0;
    repeat (n) begin
      @(negedge clk); #1;
      if (out_valid) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1
    chk(!out_valid && !out_en && !srq, "R1 reset outputs", {out_valid, out_en, srq}, 0);

    talk_addr = 1; wait_mode = 1;
    quiet(20, "R6 no pending reading");

    // R7 R11 wait mode
    talk_addr = 0;
    new_reading();
    measure();
    chk(srq == 1, "R11 srq after gate close", srq, 1);
    chk(!out_valid && !out_en, "R6 not addressed", out_valid, 0);
    talk_addr = 1;
    get_bytes(0, 15, 0);
    #1;
    chk(srq == 0, "R7 pending cleared after LF", srq, 0);
    quiet(10, "R7 nothing after string");

    // R7 blocked by counter reset
    cnt_reset = 1;
    measure();
    cnt_reset = 0;
    chk(srq == 0, "R7 cnt_reset blocks set", srq, 0);
    quiet(10, "R7 blocked set sends nothing");

    // R11 continue mode, R10 strap
    wait_mode = 0; talk_addr = 0; talk_strap = 1;
    new_reading();
    measure();
    chk(srq == 0, "R11 no srq in continue mode", srq, 0);
    get_bytes(0, 15, 30);
    talk_strap = 0; talk_addr = 1; wait_mode = 1;

    // R9 command phase mid-string
    new_reading();
    measure();
    get_bytes(0, 4, 0);
    @(negedge clk) bus_cmd = 1;
    #1;
    chk(!out_valid && !out_en && out_data == 0, "R9 quiet in command phase",
        {out_valid, out_en, out_data}, 0);
    quiet(5, "R9 held in command phase");
    bus_cmd = 0;
    get_bytes(5, 15, 0);

    // R7 set and clear in the same cycle
    new_reading();
    measure();
    gate = 1;
    get_bytes(0, 14, 0);
    @(negedge clk);
    out_accept = 1; gate = 0;
    #1;
    chk(out_valid && out_last, "R8 LF offered", out_last, 1);
    @(negedge clk);
    out_accept = 0;
    #1;
    chk(srq == 1, "R7 set wins over clear", srq, 1);
    chk(out_valid && out_data == exp_char(0), "R7 new string starts", out_data, exp_char(0));
    get_bytes(0, 15, 20);
    #1;
    chk(srq == 0, "R7 cleared after second string", srq, 0);

    // R12 on-the-fly
    fly_mode = 1; wait_mode = 0;
    new_reading();
    get_bytes(0, 15, 10);
    get_bytes(0, 15, 10);
    fly_mode = 0;
    quiet(5, "R12 stops when fly mode off");

    // random readings
    wait_mode = 1;
    for (int n = 0; n < 40; n++) begin
      new_reading();
      measure();
      chk(srq == 1, "R11 srq random", srq, 1);
      get_bytes(0, 15, $urandom % 50);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule